// File: doc/BRIEF.md
# FIR Instruction Address Sequencer

This block turns one decoded filter instruction into the read-address streams a multiply-accumulate FIR engine needs. A one-cycle start pulse captures the instruction fields, a data start pointer and a coefficient base. The sequencer then produces one read per tap for each filter output. Data address A begins at the newest sample. Data address B begins at the far end of a folded symmetric filter. Coefficient address C steps through the taps inside a power-of-two modulo region.

Each read carries a tap-valid strobe, and the final read of every output also carries a last-tap strobe. When the final output completes, the sequencer pulses done and publishes the start pointer moved by a signed step, so the next run can begin from it. A two-clock mode holds each read for two cycles, which suits complex filters. While a run is in progress, new start pulses are ignored.

Top module: `fir_addr_seq`

## Requirements
- R1: While reset is held, all three addresses, the published pointer, tap-valid, last-tap, done and busy are 0.
- R2: An accepted start at a clock edge makes the first read visible after that edge, with tap-valid 1, A equal to the start pointer, B equal to the start pointer plus the sign-extended 9-bit initial offset, and C equal to the coefficient base.
- R3: Each output takes reads-field+1 reads, and a run produces outputs-field+1 outputs. Last-tap is 1 exactly on the final read of each output and only together with tap-valid.
- R4: After any read that is not the final read of its output, A moves by step-1. After the final read of an output, A moves by step-2. For both 2-bit codes, 0 means 0, 1 means -1, 2 means -2 and 3 means 0.
- R5: Within an output, B moves after each read by its 2-bit code, where 0 means 0, 1 means +1, 2 means +2 and 3 means 0. At the start of every later output, B equals the new A plus the initial offset.
- R6: The coefficient stride code k gives a stride of 0 when k=0 and 2^(k-1) otherwise. C advances by the stride within the aligned region of 2^(blk+3) words that holds the base, where blk is the 3-bit block code. C returns to the base for each new output.
- R7: When the two-clock bit is 1, each read lasts two cycles. Tap-valid is 1 only in the first cycle, and A, B and C stay unchanged across both cycles.
- R8: In the cycle after the last read ends, done is 1 for exactly one cycle and busy falls. The published pointer then equals the start pointer plus the sign-extended 9-bit pointer step, modulo 1024, and it keeps that value until the next run ends.
- R9: A start pulse, or a change of any instruction input, while busy has no effect on the running address sequence.
- R10: Data addresses are 10 bits wide and wrap modulo 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| start_ptr_i | input | 10 | Newest-sample data address |
| coef_base_i | input | 10 | First coefficient address |
| blk_code_i | input | 3 | Coefficient modulo region code |
| nout_m1_i | input | 9 | Outputs per run minus 1 |
| ptr_step_i | input | 9 | Signed start-pointer advance |
| init_off_i | input | 9 | Signed B offset from A |
| reads_m1_i | input | 9 | Reads per output minus 1 |
| two_clk_i | input | 1 | Two clocks per read |
| a_step1_i | input | 2 | A step code for non-final reads |
| a_step2_i | input | 2 | A step code after final read |
| b_step_i | input | 2 | B step code |
| c_step_i | input | 3 | Coefficient stride code |
| addr_a_o | output | 10 | Data address A |
| addr_b_o | output | 10 | Data address B |
| addr_c_o | output | 10 | Coefficient address |
| tap_valid_o | output | 1 | A read is presented |
| last_tap_o | output | 1 | Final read of an output |
| done_o | output | 1 | Run finished pulse |
| busy_o | output | 1 | Run in progress |
| next_ptr_o | output | 10 | Updated start pointer |

## Verification
The assertions assume that the instruction inputs only matter when a start is accepted, and that the coefficient base and region code describe a region that fits in 10 bits, which holds for every 3-bit code. The stimulus drives inputs on falling edges, changes fields and pulses start in the middle of a run only to test that they are ignored, and keeps the counts small so that every step code, stride code, block code and both read modes are covered. Start pointers near 0 and 1023 exercise the wrap.

// File: rtl/fir_seq_pkg.sv
package fir_seq_pkg;
  typedef logic [1:0] dcode_t;
  typedef logic [2:0] ccode_t;

  // data A step: 0->0, 1->-1, 2->-2, 3->0
  function automatic logic signed [2:0] a_step(input dcode_t code);
    case (code)
      2'd1:    return -3'sd1;
      2'd2:    return -3'sd2;
      default: return 3'sd0;
    endcase
  endfunction

  // data B step: 0->0, 1->+1, 2->+2, 3->0
  function automatic logic signed [2:0] b_step(input dcode_t code);
    case (code)
      2'd1:    return 3'sd1;
      2'd2:    return 3'sd2;
      default: return 3'sd0;
    endcase
  endfunction
endpackage

// File: rtl/fir_seq_ctrl.sv
module fir_seq_ctrl #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [CW-1:0] reads_m1_i,
  input  logic [CW-1:0] nout_m1_i,
  input  logic          two_clk_i,
  output logic          load_o,
  output logic          adv_o,
  output logic          last_o,
  output logic          final_o,
  output logic          busy_o,
  output logic          tap_valid_o,
  output logic          last_tap_o,
  output logic          done_o
);
  logic          busy_q, phase_q, two_q;
  logic [CW-1:0] tap_q, out_q, reads_q, nout_q;

  assign load_o  = start_i & ~busy_q;
  assign adv_o   = busy_q & (~two_q | phase_q);
  assign last_o  = (tap_q == reads_q);
  assign final_o = last_o & (out_q == nout_q);
  assign busy_o  = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; phase_q <= 1'b0; two_q <= 1'b0;
      tap_q <= '0; out_q <= '0; reads_q <= '0; nout_q <= '0;
      tap_valid_o <= 1'b0; last_tap_o <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        busy_q      <= 1'b1;
        phase_q     <= 1'b0;
        tap_q       <= '0;
        out_q       <= '0;
        reads_q     <= reads_m1_i;
        nout_q      <= nout_m1_i;
        two_q       <= two_clk_i;
        tap_valid_o <= 1'b1;
        last_tap_o  <= (reads_m1_i == '0);
      end else if (busy_q) begin
        if (adv_o) begin
          phase_q <= 1'b0;
          if (final_o) begin
            busy_q      <= 1'b0;
            tap_valid_o <= 1'b0;
            last_tap_o  <= 1'b0;
            done_o      <= 1'b1;
          end else if (last_o) begin
            tap_q       <= '0;
            out_q       <= out_q + CW'(1);
            tap_valid_o <= 1'b1;
            last_tap_o  <= (reads_q == '0);
          end else begin
            tap_q       <= tap_q + CW'(1);
            tap_valid_o <= 1'b1;
            last_tap_o  <= (tap_q + CW'(1) == reads_q);
          end
        end else begin
          phase_q     <= 1'b1;
          tap_valid_o <= 1'b0;
          last_tap_o  <= 1'b0;
        end
      end
    end
  end

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    last_tap_o |-> tap_valid_o); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i) |=> ($stable(reads_q) && $stable(nout_q) && $stable(two_q))); // R9
  AST_TWO_CLK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tap_valid_o && two_q) |=> !tap_valid_o); // R7
endmodule

// File: rtl/fir_data_addr.sv
module fir_data_addr
  import fir_seq_pkg::*;
#(
  parameter int AW = 10,
  parameter int SW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          last_i,
  input  logic          final_i,
  input  logic [AW-1:0] start_ptr_i,
  input  logic [SW-1:0] init_off_i,
  input  logic [SW-1:0] ptr_step_i,
  input  dcode_t        s1_code_i,
  input  dcode_t        s2_code_i,
  input  dcode_t        b_code_i,
  output logic [AW-1:0] a_o,
  output logic [AW-1:0] b_o,
  output logic [AW-1:0] ptr_o
);
  localparam int XW = AW - SW;

  logic [AW-1:0] start_q, off_q, pstep_q;
  dcode_t        s1_q, s2_q, bc_q;
  logic [AW-1:0] s1x, s2x, bx, off_in, pstep_in, a_after_out;

  function automatic logic [AW-1:0] sx3(input logic signed [2:0] v);
    return {{(AW-3){v[2]}}, v};
  endfunction

  assign off_in      = {{XW{init_off_i[SW-1]}}, init_off_i};
  assign pstep_in    = {{XW{ptr_step_i[SW-1]}}, ptr_step_i};
  assign s1x         = sx3(a_step(s1_q));
  assign s2x         = sx3(a_step(s2_q));
  assign bx          = sx3(b_step(bc_q));
  assign a_after_out = a_o + s2x;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_o <= '0; b_o <= '0; ptr_o <= '0;
      start_q <= '0; off_q <= '0; pstep_q <= '0;
      s1_q <= '0; s2_q <= '0; bc_q <= '0;
    end else if (load_i) begin
      a_o     <= start_ptr_i;
      b_o     <= start_ptr_i + off_in;
      start_q <= start_ptr_i;
      off_q   <= off_in;
      pstep_q <= pstep_in;
      s1_q    <= s1_code_i;
      s2_q    <= s2_code_i;
      bc_q    <= b_code_i;
    end else if (adv_i) begin
      if (last_i) begin
        a_o <= a_after_out;
        b_o <= a_after_out + off_q;
      end else begin
        a_o <= a_o + s1x;
        b_o <= b_o + bx;
      end
      if (final_i) ptr_o <= start_q + pstep_q;
    end
  end

  AST_B_REANCHORED: assert property (@(posedge clk) disable iff (rst)
    (adv_i && last_i && !final_i && !load_i) |=> (b_o - a_o == off_q)); // R5
endmodule

// File: rtl/fir_coef_addr.sv
module fir_coef_addr
  import fir_seq_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          last_i,
  input  logic [AW-1:0] base_i,
  input  ccode_t        blk_i,
  input  ccode_t        stride_i,
  output logic [AW-1:0] c_o
);
  logic [AW-1:0] base_q, mask, stride;
  ccode_t        blk_q, st_q;

  always_comb begin
    for (int i = 0; i < AW; i++) begin
      mask[i]   = (i < int'(blk_q) + 3);
      stride[i] = (st_q != 3'd0) && (i == int'(st_q) - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_o <= '0; base_q <= '0; blk_q <= '0; st_q <= '0;
    end else if (load_i) begin
      c_o    <= base_i;
      base_q <= base_i;
      blk_q  <= blk_i;
      st_q   <= stride_i;
    end else if (adv_i) begin
      if (last_i) c_o <= base_q;
      else        c_o <= (c_o & ~mask) | ((c_o + stride) & mask);
    end
  end

  AST_COEF_IN_REGION: assert property (@(posedge clk) disable iff (rst)
    (((c_o ^ base_q) & ~mask) == '0)); // R6
endmodule

// File: rtl/fir_addr_seq.sv
module fir_addr_seq
  import fir_seq_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 9,
  parameter int SW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] start_ptr_i,
  input  logic [AW-1:0] coef_base_i,
  input  logic [2:0]    blk_code_i,
  input  logic [CW-1:0] nout_m1_i,
  input  logic [SW-1:0] ptr_step_i,
  input  logic [SW-1:0] init_off_i,
  input  logic [CW-1:0] reads_m1_i,
  input  logic          two_clk_i,
  input  logic [1:0]    a_step1_i,
  input  logic [1:0]    a_step2_i,
  input  logic [1:0]    b_step_i,
  input  logic [2:0]    c_step_i,
  output logic [AW-1:0] addr_a_o,
  output logic [AW-1:0] addr_b_o,
  output logic [AW-1:0] addr_c_o,
  output logic          tap_valid_o,
  output logic          last_tap_o,
  output logic          done_o,
  output logic          busy_o,
  output logic [AW-1:0] next_ptr_o
);
  logic load, adv, last, fin;

  fir_seq_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .reads_m1_i(reads_m1_i), .nout_m1_i(nout_m1_i), .two_clk_i(two_clk_i),
    .load_o(load), .adv_o(adv), .last_o(last), .final_o(fin),
    .busy_o(busy_o), .tap_valid_o(tap_valid_o), .last_tap_o(last_tap_o),
    .done_o(done_o)
  );

  fir_data_addr #(.AW(AW), .SW(SW)) u_data (
    .clk(clk), .rst(rst), .load_i(load), .adv_i(adv), .last_i(last),
    .final_i(fin), .start_ptr_i(start_ptr_i), .init_off_i(init_off_i),
    .ptr_step_i(ptr_step_i), .s1_code_i(a_step1_i), .s2_code_i(a_step2_i),
    .b_code_i(b_step_i), .a_o(addr_a_o), .b_o(addr_b_o), .ptr_o(next_ptr_o)
  );

  fir_coef_addr #(.AW(AW)) u_coef (
    .clk(clk), .rst(rst), .load_i(load), .adv_i(adv), .last_i(last),
    .base_i(coef_base_i), .blk_i(blk_code_i), .stride_i(c_step_i),
    .c_o(addr_c_o)
  );

  AST_HOLD_SECOND_CLK: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !tap_valid_o && !done_o) |->
      ($stable(addr_a_o) && $stable(addr_b_o) && $stable(addr_c_o))); // R7
endmodule

// File: tb/test_fir_addr_seq.sv
`timescale 1ns/1ps
module test_fir_addr_seq;
  logic       clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [9:0] sptr = '0, cbase = '0;
  logic [2:0] blk = '0, cst = '0;
  logic [8:0] nout = '0, pstep = '0, ioff = '0, reads = '0;
  logic       two = 1'b0;
  logic [1:0] s1 = '0, s2 = '0, bs = '0;
  logic [9:0] a, b, c, nptr;
  logic       valid, lastt, done, busy;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fir_addr_seq i_fir_addr_seq (
    .clk(clk), .rst(rst), .start_i(start), .start_ptr_i(sptr),
    .coef_base_i(cbase), .blk_code_i(blk), .nout_m1_i(nout),
    .ptr_step_i(pstep), .init_off_i(ioff), .reads_m1_i(reads),
    .two_clk_i(two), .a_step1_i(s1), .a_step2_i(s2), .b_step_i(bs),
    .c_step_i(cst), .addr_a_o(a), .addr_b_o(b), .addr_c_o(c),
    .tap_valid_o(valid), .last_tap_o(lastt), .done_o(done),
    .busy_o(busy), .next_ptr_o(nptr)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sx9(input logic [8:0] v);
    return v[8] ? int'(v) - 512 : int'(v);
  endfunction
  function automatic int astep(input logic [1:0] k);
    return (k == 2'd1) ? -1 : (k == 2'd2) ? -2 : 0;
  endfunction
  function automatic int bstep(input logic [1:0] k);
    return (k == 2'd1) ? 1 : (k == 2'd2) ? 2 : 0;
  endfunction

  task automatic run(input int st, input int off, input int ps, input int rd,
                     input int no, input int base, input int bk, input int cs,
                     input int k1, input int k2, input int kb, input bit tc,
                     input bit poke);
    int ea, eb, ec, m, stv, aoff;
    @(negedge clk);
    sptr = 10'(st); ioff = 9'(off); pstep = 9'(ps); reads = 9'(rd);
    nout = 9'(no); cbase = 10'(base); blk = 3'(bk); cst = 3'(cs);
    s1 = 2'(k1); s2 = 2'(k2); bs = 2'(kb); two = tc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    aoff = sx9(9'(off));
    m = (8 << bk) - 1;
    stv = (cs == 0) ? 0 : (1 << (cs - 1));
    ea = st & 1023; eb = (st + aoff) & 1023; ec = base;
    for (int o = 0; o <= no; o++) begin
      for (int t = 0; t <= rd; t++) begin
        chk("R2 R3 valid", int'(valid), 1);
        chk("R3 last", int'(lastt), (t == rd) ? 1 : 0);
        chk("R4 R10 addr A", int'(a), ea);
        chk("R5 addr B", int'(b), eb);
        chk("R6 addr C", int'(c), ec);
        chk("R8 done low", int'(done), 0);
        if (poke && o == 0 && t == 0) begin
          start = 1'b1; sptr = ~sptr; reads = reads + 9'd3; s1 = ~s1;
          blk = ~blk; ioff = ~ioff; two = ~two; cst = ~cst; nout = ~nout;
        end
        @(negedge clk);
        start = 1'b0;
        if (tc) begin
          chk("R7 gap valid", int'(valid), 0);
          chk("R7 hold A", int'(a), ea);
          chk("R7 hold B", int'(b), eb);
          chk("R7 hold C", int'(c), ec);
          @(negedge clk);
        end
        if (t == rd) begin
          ea = (ea + astep(2'(k2))) & 1023;
          eb = (ea + aoff) & 1023;
          ec = base;
        end else begin
          ea = (ea + astep(2'(k1))) & 1023;
          eb = (eb + bstep(2'(kb))) & 1023;
          ec = (ec & ~m & 1023) | ((ec + stv) & m);
        end
      end
    end
    chk("R8 done", int'(done), 1);
    chk("R8 busy", int'(busy), 0);
    chk("R8 valid", int'(valid), 0);
    chk("R8 ptr", int'(nptr), (st + sx9(9'(ps))) & 1023);
    @(negedge clk);
    chk("R8 done once", int'(done), 0);
    chk("R8 ptr held", int'(nptr), (st + sx9(9'(ps))) & 1023);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 A", int'(a), 0); chk("R1 B", int'(b), 0); chk("R1 C", int'(c), 0);
    chk("R1 valid", int'(valid), 0); chk("R1 last", int'(lastt), 0);
    chk("R1 done", int'(done), 0); chk("R1 busy", int'(busy), 0);
    chk("R1 ptr", int'(nptr), 0);
    rst = 1'b0;
    // step-code sweep with wrap near address 0 (R4 R5 R10)
    for (int k1 = 0; k1 < 4; k1++)
      for (int k2 = 0; k2 < 4; k2++)
        for (int kb = 0; kb < 4; kb++)
          run((k1 * 300 + k2 * 97 + kb) % 1024, -5, (k1 * 16 + kb) - 20, 2, 2,
              17, 7, 1, k1, k2, kb, 1'b0, 1'b0);
    // coefficient stride and region sweep (R6)
    for (int bk = 0; bk < 8; bk++)
      for (int cs = 0; cs < 8; cs++)
        run(1020, -7, 200, 10, 1, 1000 - bk * 13, bk, cs, 1, 2, 1, 1'b0, 1'b0);
    // two clocks per read (R7)
    run(5, -3, -10, 3, 2, 64, 2, 3, 1, 1, 2, 1'b1, 1'b0);
    run(1023, 4, 255, 0, 3, 9, 0, 2, 2, 0, 1, 1'b1, 1'b0);
    // single read and long single-tap run (R3 R8)
    run(0, 0, -256, 0, 0, 0, 7, 0, 1, 1, 1, 1'b0, 1'b0);
    run(700, -1, 511, 0, 40, 3, 1, 4, 1, 2, 1, 1'b0, 1'b0);
    // start and field changes while busy are ignored (R9)
    run(100, -11, 48, 5, 2, 33, 3, 2, 1, 2, 1, 1'b0, 1'b1);
    run(900, 6, -48, 4, 1, 512, 4, 5, 2, 1, 2, 1'b1, 1'b1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule